// File: doc/BRIEF.md
# Masked Rotate Config Read-Modify-Write Unit

This unit updates one 32-bit entry of a banked configuration register array in a single read-modify-write. It takes a 32-bit instruction word through a valid/ready handshake. From a set of scratch registers it picks one operand. It keeps only a low field of chosen width, rotates that field right, and can clear the matching rotated region of the old entry. It then combines operand and old value with one of eight ALU operations and writes the result back.

Each operation takes two cycles. In the cycle after acceptance the unit reads the entry, with the array answering combinationally, and computes the result. In the next cycle it drives a one-cycle write strobe. Ready is low only in the read cycle, so the issuer can hand over the next instruction while the write is in progress. An instruction word with a foreign opcode is refused and flagged.

Top module: `cfg_rmw_unit`

## Requirements
- R1: A word whose bits [31:24] are not 0xB8 is not executed. While ready is high, it raises illegal_op in the same cycle and causes no read strobe and no write strobe.
- R2: Bits [19:15] give a width code w. The operand is the selected scratch value ANDed with a mask of w+1 low ones, so w=31 keeps all 32 bits.
- R3: Bits [14:10] give a rotate amount r. The masked operand and the mask are both rotated right circularly by r positions, with bits leaving bit 0 re-entering at bit 31.
- R4: Bit [23] is the keep bit. When it is 0, the rotated mask region of the old entry is cleared before the ALU step. When it is 1, the old entry is used unchanged.
- R5: Bits [22:20] choose the operation of old value V with operand S: 0 OR, 1 AND, 2 XOR, 3 ADD, 4 V|~S, 5 V&~S, 6 V^~S, 7 V-S. The result is truncated to 32 bits.
- R6: Bits [9:8] select the scratch register. Values 0 to 2 pick that register; 3 picks the register numbered by thread_id.
- R7: The read and write address is {bank_id, bits [7:0]}, and both are taken at acceptance.
- R8: An instruction is accepted on an edge where instr_valid and instr_ready are high and the opcode is legal. The following cycle has instr_ready low and cfg_rd_en high. The cycle after that has cfg_wr_en high for exactly one cycle.
- R9: Back-to-back instructions start at most every other cycle. The next instruction may be accepted in the write cycle of the previous one, and it reads the value that was just written.
- R10: After reset instr_ready is high and cfg_rd_en, cfg_wr_en and illegal_op are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Unit can take an instruction |
| instr_word | input | 32 | Instruction word |
| thread_id | input | THR_W | Issuing thread number |
| bank_id | input | BANK_W | State bank of the issuing thread |
| scratch_flat | input | 32*2^THR_W | Scratch registers, register k at bits [32k+31:32k] |
| cfg_rd_en | output | 1 | Read strobe into the config array |
| cfg_rd_addr | output | BANK_W+8 | Read address |
| cfg_rd_data | input | 32 | Read data, valid in the same cycle |
| cfg_wr_en | output | 1 | One-cycle write strobe |
| cfg_wr_addr | output | BANK_W+8 | Write address |
| cfg_wr_data | output | 32 | Write data |
| illegal_op | output | 1 | Offered word has a foreign opcode |

## Verification
The illegal_op flag is due in the same cycle the word is offered. The read strobe and read address are due one edge after acceptance, and the write strobe, address and data are due two edges after it. The bench drives on falling edges and samples each of these on the falling edge inside the cycle where it is due. It then confirms on the following falling edge that the write strobe has dropped. For back-to-back issue, the bench holds the second word through the read cycle of the first. It checks that the second word is accepted only on the edge that ends the write cycle, and that its result is built on the value just written.

// File: rtl/cfg_rmw_pkg.sv
package cfg_rmw_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;
  localparam logic [7:0] OPC_RMW = 8'hB8;

  typedef enum logic [2:0] {
    ALU_OR   = 3'd0,
    ALU_AND  = 3'd1,
    ALU_XOR  = 3'd2,
    ALU_ADD  = 3'd3,
    ALU_ORN  = 3'd4,
    ALU_ANDN = 3'd5,
    ALU_XORN = 3'd6,
    ALU_SUB  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic [7:0]       opcode;
    logic             keep_old;
    alu_op_e          alu;
    logic [4:0]       width;
    logic [4:0]       rot;
    logic [1:0]       src_sel;
    logic [IDX_W-1:0] idx;
  } instr_t;
endpackage

// File: rtl/cfg_rmw_rotr.sv
module cfg_rmw_rotr
  import cfg_rmw_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         dout
);
  localparam int SH_W = $clog2(W);

  logic [W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][D-1:0], stg[s][W-1:D]} : stg[s];
  end

  assign dout = stg[SH_W];
endmodule

// File: rtl/cfg_rmw_decode.sv
module cfg_rmw_decode
  import cfg_rmw_pkg::*;
#(
  parameter int THR_W = 2,
  localparam int NSCR = 1 << THR_W
) (
  input  logic [DATA_W-1:0]      word,
  input  logic [THR_W-1:0]       thread_id,
  input  logic [NSCR*DATA_W-1:0] scratch_flat,
  output instr_t                 fields,
  output logic                   legal,
  output logic [DATA_W-1:0]      src_val
);
  logic [THR_W-1:0] pick;

  always_comb begin
    fields = instr_t'(word);
    legal  = (fields.opcode == OPC_RMW);
    if (fields.src_sel == 2'd3) pick = thread_id;
    else                        pick = THR_W'(fields.src_sel);
    src_val = scratch_flat[pick*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/cfg_rmw_shaper.sv
module cfg_rmw_shaper
  import cfg_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] src_val,
  input  logic [4:0]        width,
  input  logic [4:0]        rot,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] region
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] masked;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (5'(i) <= width);
  end

  assign masked = src_val & mask;

  cfg_rmw_rotr #(.W(DATA_W)) u_rot_op (
    .din (masked),
    .amt (rot),
    .dout(operand)
  );

  cfg_rmw_rotr #(.W(DATA_W)) u_rot_mask (
    .din (mask),
    .amt (rot),
    .dout(region)
  );
endmodule

// File: rtl/cfg_rmw_alu.sv
module cfg_rmw_alu
  import cfg_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] region,
  input  logic              keep_old,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] base;

  always_comb begin
    base = keep_old ? old_val : (old_val & ~region);
    unique case (op)
      ALU_OR:   result = base | operand;
      ALU_AND:  result = base & operand;
      ALU_XOR:  result = base ^ operand;
      ALU_ADD:  result = base + operand;
      ALU_ORN:  result = base | ~operand;
      ALU_ANDN: result = base & ~operand;
      ALU_XORN: result = base ^ ~operand;
      ALU_SUB:  result = base - operand;
      default:  result = base;
    endcase
  end
endmodule

// File: rtl/cfg_rmw_unit.sv
module cfg_rmw_unit
  import cfg_rmw_pkg::*;
#(
  parameter int THR_W  = 2,
  parameter int BANK_W = 1,
  localparam int NSCR   = 1 << THR_W,
  localparam int ADDR_W = BANK_W + IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   instr_valid,
  output logic                   instr_ready,
  input  logic [DATA_W-1:0]      instr_word,
  input  logic [THR_W-1:0]       thread_id,
  input  logic [BANK_W-1:0]      bank_id,
  input  logic [NSCR*DATA_W-1:0] scratch_flat,
  output logic                   cfg_rd_en,
  output logic [ADDR_W-1:0]      cfg_rd_addr,
  input  logic [DATA_W-1:0]      cfg_rd_data,
  output logic                   cfg_wr_en,
  output logic [ADDR_W-1:0]      cfg_wr_addr,
  output logic [DATA_W-1:0]      cfg_wr_data,
  output logic                   illegal_op
);
  instr_t            fields;
  logic              legal;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] operand_d, region_d;
  logic [DATA_W-1:0] result;

  logic              busy_q, busy_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] operand_q, region_q;
  logic              keep_q;
  alu_op_e           alu_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              accept;

  cfg_rmw_decode #(.THR_W(THR_W)) u_dec (
    .word        (instr_word),
    .thread_id   (thread_id),
    .scratch_flat(scratch_flat),
    .fields      (fields),
    .legal       (legal),
    .src_val     (src_val)
  );

  cfg_rmw_shaper u_shp (
    .src_val(src_val),
    .width  (fields.width),
    .rot    (fields.rot),
    .operand(operand_d),
    .region (region_d)
  );

  cfg_rmw_alu u_alu (
    .old_val (cfg_rd_data),
    .operand (operand_q),
    .region  (region_q),
    .keep_old(keep_q),
    .op      (alu_q),
    .result  (result)
  );

  // Handshake and sequencing
  always_comb begin
    instr_ready = !busy_q;
    accept      = instr_valid && instr_ready && legal;
    illegal_op  = instr_valid && instr_ready && !legal;
    busy_d      = accept;
    wr_d        = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      wr_q   <= wr_d;
    end
  end

  // Operand capture at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_q <= '0;
      region_q  <= '0;
      keep_q    <= 1'b0;
      alu_q     <= ALU_OR;
      addr_q    <= '0;
    end else if (accept) begin
      operand_q <= operand_d;
      region_q  <= region_d;
      keep_q    <= fields.keep_old;
      alu_q     <= fields.alu;
      addr_q    <= {bank_id, fields.idx};
    end
  end

  // Result capture in the read cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (busy_q) begin
      wr_addr_q <= addr_q;
      wr_data_q <= result;
    end
  end

  assign cfg_rd_en   = busy_q;
  assign cfg_rd_addr = addr_q;
  assign cfg_wr_en   = wr_q;
  assign cfg_wr_addr = wr_addr_q;
  assign cfg_wr_data = wr_data_q;
endmodule

// File: rtl/cfg_rmw_unit_chk.sv
module cfg_rmw_unit_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [31:0]       instr_word,
  input logic              cfg_rd_en,
  input logic [ADDR_W-1:0] cfg_rd_addr,
  input logic              cfg_wr_en,
  input logic [ADDR_W-1:0] cfg_wr_addr,
  input logic              illegal_op
);
  logic acc;
  assign acc = instr_valid && instr_ready && (instr_word[31:24] == 8'hB8);

  assert_rd_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (cfg_rd_en && !instr_ready));

  assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_en |=> cfg_wr_en);

  assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> !cfg_wr_en);

  assert_rd_not_repeated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_en |=> !cfg_rd_en);

  assert_wr_addr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |-> (cfg_wr_addr == $past(cfg_rd_addr)));

  assert_illegal_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> !cfg_rd_en);
endmodule

bind cfg_rmw_unit cfg_rmw_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_valid(instr_valid),
  .instr_ready(instr_ready),
  .instr_word (instr_word),
  .cfg_rd_en  (cfg_rd_en),
  .cfg_rd_addr(cfg_rd_addr),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wr_addr(cfg_wr_addr),
  .illegal_op (illegal_op)
);

// File: tb/tb_cfg_rmw_unit.sv
module tb_cfg_rmw_unit;
  localparam int THR_W  = 2;
  localparam int BANK_W = 1;
  localparam int ADDR_W = BANK_W + 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              instr_valid;
  logic              instr_ready;
  logic [31:0]       instr_word;
  logic [THR_W-1:0]  thread_id;
  logic [BANK_W-1:0] bank_id;
  logic [127:0]      scratch_flat;
  logic              cfg_rd_en;
  logic [ADDR_W-1:0] cfg_rd_addr;
  logic [31:0]       cfg_rd_data;
  logic              cfg_wr_en;
  logic [ADDR_W-1:0] cfg_wr_addr;
  logic [31:0]       cfg_wr_data;
  logic              illegal_op;

  logic [31:0] mem [DEPTH];
  logic [31:0] scr [4];
  int n_chk;
  int n_fail;

  cfg_rmw_unit #(.THR_W(THR_W), .BANK_W(BANK_W)) dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .thread_id(thread_id), .bank_id(bank_id),
    .scratch_flat(scratch_flat), .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .illegal_op(illegal_op)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign cfg_rd_data  = mem[cfg_rd_addr];
  assign scratch_flat = {scr[3], scr[2], scr[1], scr[0]};

  always @(posedge clk) if (cfg_wr_en) mem[cfg_wr_addr] <= cfg_wr_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotr(input logic [31:0] v, input int r);
    int k = r % 32;
    if (k == 0) return v;
    return (v >> k) | (v << (32 - k));
  endfunction

  function automatic logic [31:0] mk(input bit keep, input int op, input int w, input int r,
                                     input int sel, input int idx);
    return {8'hB8, keep, 3'(op), 5'(w), 5'(r), 2'(sel), 8'(idx)};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] w, input logic [31:0] old,
                                        input int tid);
    logic [31:0] m, s, v, rm;
    int sel = int'(w[9:8]);
    m  = (w[19:15] == 5'd31) ? 32'hFFFF_FFFF : ((32'd2 << w[19:15]) - 32'd1);
    s  = rotr(scr[(sel == 3) ? tid : sel] & m, int'(w[14:10]));
    rm = rotr(m, int'(w[14:10]));
    v  = w[23] ? old : (old & ~rm);
    case (w[22:20])
      3'd0: return v | s;
      3'd1: return v & s;
      3'd2: return v ^ s;
      3'd3: return v + s;
      3'd4: return v | ~s;
      3'd5: return v & ~s;
      3'd6: return v ^ ~s;
      default: return v - s;
    endcase
  endfunction

  task automatic run_op(input logic [31:0] w, input int tid, input int bnk, input string req);
    logic [ADDR_W-1:0] a;
    logic [31:0] exp;
    a = {BANK_W'(bnk), w[7:0]};
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    thread_id = THR_W'(tid); bank_id = BANK_W'(bnk);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(cfg_rd_en && !instr_ready, "R8 read cycle", {30'd0, cfg_rd_en, instr_ready}, 32'h2);
    chk(cfg_rd_addr == a, "R7 read address", 32'(cfg_rd_addr), 32'(a));
    exp = model(w, mem[a], tid);
    @(negedge clk);
    chk(cfg_wr_en && instr_ready, "R8 write cycle", {30'd0, cfg_wr_en, instr_ready}, 32'h3);
    chk(cfg_wr_addr == a, "R7 write address", 32'(cfg_wr_addr), 32'(a));
    chk(cfg_wr_data == exp, req, cfg_wr_data, exp);
    @(negedge clk);
    chk(!cfg_wr_en, "R8 strobe one cycle", 32'(cfg_wr_en), 32'd0);
  endtask

  task automatic t_reset();
    chk(instr_ready && !cfg_rd_en && !cfg_wr_en && !illegal_op, "R10 reset state",
        {28'd0, instr_ready, cfg_rd_en, cfg_wr_en, illegal_op}, 32'h8);
  endtask

  task automatic t_alu();
    mem[9'h010] = 32'hFFFF_FFF0;
    scr[0]      = 32'h0000_0025;
    for (int op = 0; op < 8; op++) run_op(mk(1, op, 31, 0, 0, 16), 0, 0, "R5 alu mode");
    mem[9'h011] = 32'h0000_0003;
    run_op(mk(1, 7, 31, 0, 0, 17), 0, 0, "R5 sub wraps");
  endtask

  task automatic t_mask();
    scr[1]      = 32'hDEAD_BEEF;
    mem[9'h020] = 32'h0;
    run_op(mk(1, 0, 3, 0, 1, 32), 0, 0, "R2 width 4 bits");
    mem[9'h020] = 32'h0;
    run_op(mk(1, 0, 0, 0, 1, 32), 0, 0, "R2 width 1 bit");
    mem[9'h020] = 32'h0;
    run_op(mk(1, 0, 31, 0, 1, 32), 0, 0, "R2 full width");
  endtask

  task automatic t_rotate();
    scr[2]      = 32'h0000_00A7;
    mem[9'h030] = 32'h0;
    run_op(mk(1, 0, 7, 4, 2, 48), 0, 0, "R3 rotate 4");
    mem[9'h030] = 32'h0;
    run_op(mk(1, 0, 7, 28, 2, 48), 0, 0, "R3 rotate wraps");
  endtask

  task automatic t_clear();
    scr[0]      = 32'h0000_0005;
    mem[9'h040] = 32'hFFFF_FFFF;
    run_op(mk(0, 0, 7, 8, 0, 64), 0, 0, "R4 clear region");
    mem[9'h040] = 32'hFFFF_FFFF;
    run_op(mk(1, 0, 7, 8, 0, 64), 0, 0, "R4 keep old");
  endtask

  task automatic t_select();
    scr[0] = 32'h11; scr[1] = 32'h22; scr[2] = 32'h33; scr[3] = 32'h44;
    for (int s = 0; s < 3; s++) begin
      mem[9'h050] = 32'h0;
      run_op(mk(1, 0, 31, 0, s, 80), 3, 0, "R6 direct select");
    end
    for (int t = 0; t < 4; t++) begin
      mem[9'h050] = 32'h0;
      run_op(mk(1, 0, 31, 0, 3, 80), t, 0, "R6 thread select");
    end
  endtask

  task automatic t_bank();
    scr[1]      = 32'h1;
    mem[9'h160] = 32'h100;
    run_op(mk(1, 3, 31, 0, 1, 96), 0, 1, "R7 bank 1 entry");
    chk(mem[9'h060] == 32'h0, "R7 other bank untouched", mem[9'h060], 32'h0);
  endtask

  task automatic t_illegal();
    mem[9'h070] = 32'h1234_5678;
    @(negedge clk);
    instr_valid = 1'b1; instr_word = {8'h48, 24'h000070};
    #1;
    chk(illegal_op, "R1 flag raised", 32'(illegal_op), 32'd1);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(!cfg_rd_en && instr_ready, "R1 no read", {30'd0, cfg_rd_en, instr_ready}, 32'h1);
    @(negedge clk);
    chk(!cfg_wr_en && !illegal_op, "R1 no write", {30'd0, cfg_wr_en, illegal_op}, 32'h0);
    chk(mem[9'h070] == 32'h1234_5678, "R1 entry unchanged", mem[9'h070], 32'h1234_5678);
  endtask

  task automatic t_b2b();
    logic [31:0] wa, wb, ea, eb;
    scr[0]      = 32'h0000_0010;
    mem[9'h080] = 32'h0000_0100;
    wa = mk(1, 3, 31, 0, 0, 128);
    wb = mk(1, 3, 31, 0, 0, 128);
    ea = model(wa, mem[9'h080], 0);
    eb = model(wb, ea, 0);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = wa; thread_id = '0; bank_id = '0;
    @(negedge clk);
    instr_word = wb;
    chk(!instr_ready && cfg_rd_en, "R9 first read, second held", {30'd0, instr_ready, cfg_rd_en}, 32'h1);
    @(negedge clk);
    chk(instr_ready && cfg_wr_en && cfg_wr_data == ea, "R9 first write", cfg_wr_data, ea);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(cfg_rd_en && !cfg_wr_en && !instr_ready, "R9 second read", {29'd0, cfg_rd_en, cfg_wr_en, instr_ready}, 32'h4);
    @(negedge clk);
    chk(cfg_wr_en && cfg_wr_data == eb, "R9 second result chains", cfg_wr_data, eb);
    @(negedge clk);
    chk(!cfg_wr_en && !cfg_rd_en, "R9 idle after pair", {30'd0, cfg_wr_en, cfg_rd_en}, 32'h0);
  endtask

  bit done;

  initial begin
    done = 1'b0;
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
    for (int i = 0; i < 4; i++) scr[i] = 32'h0;
    instr_valid = 1'b0; instr_word = '0; thread_id = '0; bank_id = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alu();
    t_mask();
    t_rotate();
    t_clear();
    t_select();
    t_bank();
    t_illegal();
    t_b2b();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule